// File: doc/BRIEF.md
# Register-Exchange Survivor Memory for a Four-State Trellis Decoder

This block holds, for every state of a four-state trellis, the sequence of information bits along the surviving path into that state. It sits after an add-compare-select unit. On each accepted stage it takes one decision bit per state and the index of the state with the best metric. All survivor registers update together: each state copies the register of the predecessor its decision picked, then writes the newest information bit into the current slot.

The registers are never shifted. One circular write pointer of length L (the decoding depth) selects the slot written in each stage. The oldest slot, which sits one position ahead of the write pointer modulo L, supplies the decoded bit. That bit is taken from the best state's freshly updated register. The decoded bit is reported L-1 stages after the stage that produced it, so the bit is L stages deep counting the current one. Branch metric and path metric computation are done elsewhere.

Top module: `survivor_regx`

## Requirements
- R1: A synchronous active-low reset clears every survivor register, the write pointer and the fill count, and drives `dec_valid` and `dec_bit` to 0.
- R2: State indices are M-bit numbers (M = 2, so states 0 to 3). The two predecessors of state s are ((s << 1) mod 2^M) and that value plus 1. Decision bit `st_dec[s]` = 0 picks the even predecessor and 1 picks the odd one.
- R3: The bit written for state s in a stage is its most significant bit, s[M-1] (0 for states 0 and 1, 1 for states 2 and 3).
- R4: In one stage, all states copy from the register contents held before that stage. A copy never sees another state's update from the same stage, including when two states take each other's paths.
- R5: Stage n (counted from 0 after reset) writes slot n mod L. Its decoded bit is read from slot (n+1) mod L of the updated register, so it is the bit that stage n-L+1 placed on the chosen path.
- R6: The decoded bit comes from the survivor register of the state given by `st_best` in the same stage.
- R7: For the first L-1 stages after reset, `dec_valid` stays 0 and `dec_bit` keeps its reset value. From stage L-1 onward, every accepted stage raises `dec_valid` for exactly one cycle, in the cycle after the stage is accepted.
- R8: A cycle with `st_valid` = 0 changes no survivor register and does not move the pointer. In that cycle `dec_valid` is 0 and `dec_bit` holds its last value.
- R9: Suppose the decisions follow a real encoder path (a shift register whose new state is {u, old state[M-1:1]}) and `st_best` is the encoder state. Then `dec_bit` repeats the encoder input u delayed by L-1 stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | A stage's decisions are present this cycle |
| st_dec | input | 4 (2^M) | One survivor decision bit per state |
| st_best | input | 2 (M) | Index of the state with the best metric |
| dec_bit | output | 1 | Decoded information bit |
| dec_valid | output | 1 | One-cycle pulse when `dec_bit` carries a new decoded bit |

## Verification
The bench keeps unbounded per-state path histories that use no pointer. Against these it checks every decoded bit across all sixteen decision patterns combined with all four best states. If a design read the wrong slot, off by one position around the pointer wrap, it would return the bit one stage too new or too old, and these comparisons would fail. A design that updated states in sequence instead of from a snapshot would corrupt the paths when two states swap predecessors, so the bench applies swap patterns on purpose. A fill count that is off by one would show `dec_valid` a stage early or late. The bench also spreads idle cycles through the run, where a design that advanced on idle would skip a slot. An encoder-driven run and a mid-run reset confirm end-to-end recovery of the input bits and a clean restart.

// File: rtl/survivor_regx_pkg.sv
// Package: survivor_regx_pkg
// Shared helpers for the register-exchange survivor memory.
// Assumes the pointer length is at least 2.
package survivor_regx_pkg;

    // Next position of a circular pointer of length len.
    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned len);
        return (p == len - 1) ? 0 : p + 1;
    endfunction

    // Index of the predecessor chosen by decision d for state s in a 2^m-state trellis.
    function automatic int unsigned pred_of(input int unsigned s, input int unsigned d,
                                            input int unsigned m);
        return ((s << 1) & ((1 << m) - 1)) | (d & 1);
    endfunction

endpackage

// File: rtl/surv_ptr.sv
// Module: surv_ptr
// Circular write pointer of length L, the matching read position, a one-hot
// write mask and a saturating fill count that marks when the oldest slot holds
// real data.
// Assumes: en is high exactly in the cycles that accept a trellis stage.
module surv_ptr #(
    parameter int L  = 15,
    parameter int PW = $clog2(L)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [L-1:0]  wr_mask,
    output logic          filled
);
    import survivor_regx_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(L - 1);

    logic [PW-1:0] fill_q;

    // Advance the write pointer once per accepted stage, wrapping at L.
    always_ff @(posedge clk) begin
        if (!rst_n)  wr_ptr <= '0;
        else if (en) wr_ptr <= PW'(wrap_inc(int'(wr_ptr), L));
    end

    // Count accepted stages until L-1 of them have filled the older slots.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fill_q <= '0;
        else if (en && fill_q != LAST) fill_q <= fill_q + 1'b1;
    end

    // Read slot sits one ahead of the write slot modulo L.
    always_comb rd_ptr = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;

    // One-hot select of the slot written this stage.
    always_comb wr_mask = L'(1) << wr_ptr;

    // The oldest slot carries real data once L-1 stages have been taken.
    always_comb filled = (fill_q == LAST);

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= LAST);

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wr_ptr) && $stable(fill_q));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_ptr == LAST) |=> wr_ptr == '0);

endmodule

// File: rtl/surv_cell.sv
// Module: surv_cell
// Survivor register of one trellis state. Each accepted stage it takes the
// register of the predecessor picked by its decision bit and writes the state's
// own input bit into the slot selected by the write mask.
// Assumes: cand0/cand1 are the registered (pre-stage) contents of the even and
// odd predecessors, so all states update from one snapshot.
module surv_cell #(
    parameter int   L      = 15,
    parameter int   PW     = $clog2(L),
    parameter logic NEWBIT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dec,
    input  logic [L-1:0]  cand0,
    input  logic [L-1:0]  cand1,
    input  logic [L-1:0]  wr_mask,
    input  logic [PW-1:0] wr_ptr,
    output logic [L-1:0]  path_q,
    output logic [L-1:0]  path_d
);
    logic [L-1:0] chosen;

    // Pick the surviving predecessor path.
    always_comb chosen = dec ? cand1 : cand0;

    // Overlay the newest bit on the selected slot only.
    always_comb path_d = (chosen & ~wr_mask) | (wr_mask & {L{NEWBIT}});

    // Hold the survivor path; load the updated path on each accepted stage.
    always_ff @(posedge clk) begin
        if (!rst_n)  path_q <= '0;
        else if (en) path_q <= path_d;
    end

    // R3
    newbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> path_q[$past(wr_ptr)] == NEWBIT);

    // R8
    path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(path_q));

endmodule

// File: rtl/surv_readout.sv
// Module: surv_readout
// Picks the best state's updated survivor path and registers the bit in the
// read slot as the decoded output, with a one-cycle valid pulse.
// Assumes: paths arrive flattened, state s in bits [s*L +: L].
module surv_readout #(
    parameter int L  = 15,
    parameter int M  = 2,
    parameter int NS = 1 << M,
    parameter int PW = $clog2(L)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            filled,
    input  logic [M-1:0]    best,
    input  logic [PW-1:0]   rd_ptr,
    input  logic [NS*L-1:0] paths_d,
    output logic            dec_bit,
    output logic            dec_valid
);
    logic [L-1:0] best_path;

    // Select the best state's freshly updated path.
    always_comb best_path = paths_d[int'(best) * L +: L];

    // Register the oldest slot as the decoded bit once the memory is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_bit   <= 1'b0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= en && filled;
            if (en && filled) dec_bit <= best_path[rd_ptr];
        end
    end

    // R7
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(en));

    // R8
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !dec_valid && $stable(dec_bit));

endmodule

// File: rtl/survivor_regx.sv
// Module: survivor_regx
// Register-exchange survivor memory for a 2^M-state trellis with decoding
// depth L. One circular pointer addresses every survivor register, so no
// register shifts. The decoded bit is the oldest slot of the best state.
// Assumes: M >= 2; state s' is entered from ((s' << 1) mod 2^M) | d and
// carries input bit s'[M-1].
module survivor_regx #(
    parameter int L = 15,
    parameter int M = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    input  logic [(1<<M)-1:0]   st_dec,
    input  logic [M-1:0]        st_best,
    output logic                dec_bit,
    output logic                dec_valid
);
    import survivor_regx_pkg::*;

    localparam int NS = 1 << M;
    localparam int PW = $clog2(L);

    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [L-1:0]    wr_mask;
    logic            filled;
    logic [L-1:0]    path_q [NS];
    logic [L-1:0]    path_d [NS];
    logic [NS*L-1:0] paths_flat;

    surv_ptr #(.L(L), .PW(PW)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st_valid),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .wr_mask (wr_mask),
        .filled  (filled)
    );

    for (genvar s = 0; s < NS; s++) begin : g_state
        localparam int   P0 = int'(pred_of(s, 0, M));
        localparam int   P1 = int'(pred_of(s, 1, M));
        localparam logic NB = ((s >> (M - 1)) & 1) != 0;

        surv_cell #(.L(L), .PW(PW), .NEWBIT(NB)) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (st_valid),
            .dec     (st_dec[s]),
            .cand0   (path_q[P0]),
            .cand1   (path_q[P1]),
            .wr_mask (wr_mask),
            .wr_ptr  (wr_ptr),
            .path_q  (path_q[s]),
            .path_d  (path_d[s])
        );

        // Flatten the updated path for the readout.
        assign paths_flat[s*L +: L] = path_d[s];

        // R4
        copy_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_valid && wr_ptr != '0) |=>
                path_q[s][0] == $past(st_dec[s] ? path_q[P1][0] : path_q[P0][0]));
    end

    surv_readout #(.L(L), .M(M), .NS(NS), .PW(PW)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st_valid),
        .filled    (filled),
        .best      (st_best),
        .rd_ptr    (rd_ptr),
        .paths_d   (paths_flat),
        .dec_bit   (dec_bit),
        .dec_valid (dec_valid)
    );

    // R1
    initial begin
        assert (L >= 2 && M >= 2);
    end

endmodule

// File: tb/survivor_regx_tb_top.sv
// Bench for survivor_regx: pointer-free reference paths, exhaustive decision
// and best-state sweeps, swaps, idle gaps, encoder path and mid-run reset.
module survivor_regx_tb_top;
    localparam int L    = 15;
    localparam int MAXN = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       st_valid = 1'b0;
    logic [3:0] st_dec = '0;
    logic [1:0] st_best = '0;
    logic       dec_bit;
    logic       dec_valid;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  n_stage = 0;
    logic last_bit = 1'b0;
    logic hist  [4][MAXN];
    logic nhist [4][MAXN];
    logic u_hist [MAXN];

    always #2 clk = ~clk;

    survivor_regx #(.L(L), .M(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_dec(st_dec),
        .st_best(st_best), .dec_bit(dec_bit), .dec_valid(dec_valid)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (stage %0d)", tag, what, act, exp, n_stage);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; st_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_stage = 0; last_bit = 1'b0;
        for (int s = 0; s < 4; s++) for (int k = 0; k < MAXN; k++) hist[s][k] = 1'b0;
        chk("R1", dec_valid, 1'b0, "dec_valid after reset");
        chk("R1", dec_bit, 1'b0, "dec_bit after reset");
    endtask

    // One stage: update the reference paths, drive, check at the next negedge.
    task automatic do_stage(input logic [3:0] d, input logic [1:0] b, input string tag);
        logic ev, eb;
        for (int s = 0; s < 4; s++) begin
            int p;
            p = ((s << 1) & 3) | int'(d[s]);           // R2 predecessor rule
            for (int k = 0; k < n_stage; k++) nhist[s][k] = hist[p][k];
            nhist[s][n_stage] = s[1];                  // R3 newest bit
        end
        for (int s = 0; s < 4; s++) for (int k = 0; k <= n_stage; k++) hist[s][k] = nhist[s][k];
        ev = (n_stage >= L - 1);
        eb = ev ? hist[b][n_stage - L + 1] : last_bit;
        st_valid = 1'b1; st_dec = d; st_best = b;
        @(negedge clk);
        st_valid = 1'b0;
        chk((n_stage < L - 1) ? "R7" : tag, dec_valid, ev, "dec_valid");
        chk((n_stage < L - 1) ? "R7" : tag, dec_bit, eb, "dec_bit");
        last_bit = eb;
        n_stage++;
    endtask

    task automatic do_idle();
        st_valid = 1'b0; st_dec = 4'($urandom); st_best = 2'($urandom);
        @(negedge clk);
        chk("R8", dec_valid, 1'b0, "dec_valid on idle");
        chk("R8", dec_bit, last_bit, "dec_bit hold on idle");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        // R7: fill period with varying inputs
        for (int i = 0; i < L - 1; i++) do_stage(4'($urandom), 2'($urandom), "R7");
        // R2 R3 R6: every decision pattern with every best state
        for (int d = 0; d < 16; d++)
            for (int b = 0; b < 4; b++) do_stage(4'(d), 2'(b), "R6");
        // R4: states swapping predecessors
        for (int i = 0; i < 40; i++) do_stage((i % 2) ? 4'b0101 : 4'b1010, 2'(i), "R4");
        // R5 R8: random stages with idle gaps, many pointer wraps
        for (int i = 0; i < 200; i++) begin
            do_stage(4'($urandom), 2'($urandom), "R5");
            if ($urandom_range(0, 3) == 0) do_idle();
        end
        // R1: mid-run reset, then R9 encoder-driven path
        do_reset();
        begin
            logic [1:0] es;
            es = 2'b00;
            for (int i = 0; i < 120; i++) begin
                logic u;
                logic [1:0] ns;
                logic [3:0] d;
                u = 1'($urandom);
                ns = {u, es[1]};
                d = 4'($urandom);
                d[ns] = es[0];
                u_hist[i] = u;
                do_stage(d, ns, "R9");
                if (i >= L - 1) chk("R9", dec_bit, u_hist[i - L + 1], "encoder input delayed");
                es = ns;
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule